// File: doc/BRIEF.md
# Supervisor timer compare unit

This block keeps the 64-bit compare value that schedules supervisor timer interrupts. It produces the supervisor timer-pending level by comparing that value, as an unsigned number, against a free-running 64-bit time count supplied from outside. Software reaches the compare value through a CSR write port and a combinational CSR read port. With a 32-bit data path the value is split into a low and a high half at two CSR numbers. With a 64-bit data path one CSR number covers the whole value.

The unit also chooses where the pending level comes from. A single enable bit sits in the top bit of the machine environment-configuration register, which is bit 31 of its upper half on a 32-bit path. When that bit is clear, the pending output follows a latch that machine software writes through the machine interrupt-pending CSR. When it is set, that latch is frozen and the output follows the comparator. Interrupt priority, delegation, trap entry and the time counter are outside this block.

Top module: `stcu_top`

## Requirements
- R1: After reset the compare register holds all ones. With XLEN=32, reads of CSR 0x14D and CSR 0x15D both return 0xFFFF_FFFF.
- R2: With XLEN=32, a write to CSR 0x14D replaces only compare bits 31:0 and a write to CSR 0x15D replaces only bits 63:32. The other half keeps its value, as readback shows.
- R3: While enabled, `stip_o` is 1 exactly when the time input is greater than or equal to the compare value, both taken as unsigned 64-bit numbers. This includes times with bit 63 set and comparisons that cross the half boundary.
- R4: While enabled, a pending level stays at 1 as time keeps advancing. It falls only once the compare value exceeds time, for example after software writes a larger compare value.
- R5: The compare result is registered. A change of time, or a write to the compare register, shows on `stip_o` one clock edge after the new value is present, and not before that edge.
- R6: While the enable bit is 0, `stip_o` equals a latch written through bit 5 of CSR 0x344, whatever the comparator says. Reading CSR 0x344 returns `stip_o` in bit 5 and 0 in every other bit.
- R7: While the enable bit is 1, writes to bit 5 of CSR 0x344 have no effect on the latch.
- R8: With XLEN=32 the enable bit is bit 31 of CSR 0x31A, and every other bit of that CSR reads 0. With XLEN=64 it is bit 63 of CSR 0x30A. It is 0 after reset.
- R9: After reset `stip_o` is 0, the enable bit is 0 and the latch is 0.
- R10: With HAS_TC=0 the enable bit reads 0 and ignores writes, and `stip_o` always follows the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Free-running time count |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR number for both read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for `csr_addr`, 0 if the number is not owned here |
| stip_o | output | 1 | Supervisor timer-pending level |

## Verification
The bench builds the unit with XLEN=32, so the split into two halves and the upper-half location of the enable bit are exercised directly. A second instance, built with HAS_TC=0 and fed the same inputs, shows the hardwired-off variant next to the live one. The bench sweeps time across a window of offsets around several compare values: zero, a value whose low half is all ones, a value just past the half boundary, and a value with bit 63 set. These reach the wrap-around and unsigned-sign corners, and the expected pending level is computed arithmetically in the bench.

// File: rtl/stcu_pkg.sv
package stcu_pkg;
   localparam int unsigned CMP_W      = 64;
   localparam int unsigned ADDR_W     = 12;
   localparam logic [11:0] A_CMP_LO   = 12'h14D;
   localparam logic [11:0] A_CMP_HI   = 12'h15D;
   localparam logic [11:0] A_ENV_LO   = 12'h30A;
   localparam logic [11:0] A_ENV_HI   = 12'h31A;
   localparam logic [11:0] A_MPEND    = 12'h344;
   localparam int unsigned STIP_POS   = 5;

   typedef struct packed {
      logic              we;
      logic [ADDR_W-1:0] addr;
   } csr_cmd_t;

   function automatic logic hit(csr_cmd_t c, logic [ADDR_W-1:0] a);
      return c.addr == a;
   endfunction
endpackage

// File: rtl/stcu_cmp_reg.sv
module stcu_cmp_reg
   import stcu_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  csr_cmd_t        cmd,
   input  logic [XLEN-1:0] wdata,
   output logic [CMP_W-1:0] cmp_o,
   output logic [XLEN-1:0] rdata_o
);
   localparam int unsigned HALVES = CMP_W / XLEN;

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("stcu_cmp_reg: XLEN must be 32 or 64");
      end
   endgenerate

   logic [CMP_W-1:0] cmp_q;
   assign cmp_o = cmp_q;

   generate
      if (HALVES == 1) begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             cmp_q <= '1;
            else if (cmd.we && hit(cmd, A_CMP_LO))  cmp_q <= CMP_W'(wdata);
         end
         always_comb begin
            rdata_o = '0;
            if (hit(cmd, A_CMP_LO)) rdata_o = XLEN'(cmp_q);
         end
      end else begin : g_split
         for (genvar h = 0; h < 2; h++) begin : g_half
            localparam logic [ADDR_W-1:0] MY_A = (h == 0) ? A_CMP_LO : A_CMP_HI;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                         cmp_q[h*XLEN +: XLEN] <= '1;
               else if (cmd.we && hit(cmd, MY_A))  cmp_q[h*XLEN +: XLEN] <= wdata;
            end
         end
         always_comb begin
            rdata_o = '0;
            if (hit(cmd, A_CMP_LO)) rdata_o = cmp_q[0 +: XLEN];
            if (hit(cmd, A_CMP_HI)) rdata_o = cmp_q[XLEN +: XLEN];
         end

         AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd.we && hit(cmd, A_CMP_LO)) |=> $stable(cmp_q[CMP_W-1:XLEN])); // R2
         AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd.we && hit(cmd, A_CMP_HI)) |=> $stable(cmp_q[XLEN-1:0])); // R2
      end
   endgenerate
endmodule

// File: rtl/stcu_cmp_eval.sv
module stcu_cmp_eval
   import stcu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMP_W-1:0] time_i,
   input  logic [CMP_W-1:0] cmp_i,
   output logic             pend_o
);
   logic ge;
   assign ge = (time_i >= cmp_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= 1'b0;
      else        pend_o <= ge;
   end
endmodule

// File: rtl/stcu_pend_src.sv
module stcu_pend_src
   import stcu_pkg::*;
#(
   parameter int unsigned XLEN   = 64,
   parameter bit          HAS_TC = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  csr_cmd_t        cmd,
   input  logic [XLEN-1:0] wdata,
   input  logic            cmp_pend_i,
   output logic            en_o,
   output logic            stip_o,
   output logic [XLEN-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] ENV_A   = (XLEN == 32) ? A_ENV_HI : A_ENV_LO;
   localparam int unsigned       ENV_BIT = XLEN - 1;

   logic en_q;
   logic sw_q;

   generate
      if (HAS_TC) begin : g_tc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          en_q <= 1'b0;
            else if (cmd.we && hit(cmd, ENV_A))  en_q <= wdata[ENV_BIT];
         end
      end else begin : g_no_tc
         assign en_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    sw_q <= 1'b0;
      else if (!en_q && cmd.we && hit(cmd, A_MPEND)) sw_q <= wdata[STIP_POS];
   end

   assign en_o   = en_q;
   assign stip_o = en_q ? cmp_pend_i : sw_q;

   always_comb begin
      rdata_o = '0;
      if (hit(cmd, ENV_A))   rdata_o[ENV_BIT]  = en_q;
      if (hit(cmd, A_MPEND)) rdata_o[STIP_POS] = stip_o;
   end

   AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cmd.we && hit(cmd, A_MPEND)) |=> $stable(sw_q)); // R7
endmodule

// File: rtl/stcu_top.sv
module stcu_top
   import stcu_pkg::*;
#(
   parameter int unsigned XLEN   = 64,
   parameter bit          HAS_TC = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [63:0]     time_i,
   input  logic            csr_we,
   input  logic [11:0]     csr_addr,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata,
   output logic            stip_o
);
   csr_cmd_t         cmd;
   logic [CMP_W-1:0] cmp;
   logic [XLEN-1:0]  rd_cmp, rd_src;
   logic             cmp_pend, en;

   assign cmd.we   = csr_we;
   assign cmd.addr = csr_addr;

   stcu_cmp_reg #(.XLEN(XLEN)) u_reg (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(csr_wdata),
      .cmp_o(cmp), .rdata_o(rd_cmp));

   stcu_cmp_eval u_eval (
      .clk(clk), .rst_n(rst_n), .time_i(time_i), .cmp_i(cmp), .pend_o(cmp_pend));

   stcu_pend_src #(.XLEN(XLEN), .HAS_TC(HAS_TC)) u_src (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(csr_wdata),
      .cmp_pend_i(cmp_pend), .en_o(en), .stip_o(stip_o), .rdata_o(rd_src));

   assign csr_rdata = rd_cmp | rd_src;

   logic [1:0] arm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              arm_q <= 2'd0;
      else if (arm_q != 2'd3)  arm_q <= arm_q + 2'd1;
   end

   AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q == 2'd3 && en && $stable(en) && $stable(time_i) && $stable(cmp))
      |=> (!en || $stable(stip_o))); // R4
endmodule

// File: tb/stcu_top_tb.sv
module stcu_top_tb;
   localparam int XLEN = 32;
   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [63:0]     time_i = '0;
   logic            csr_we = 1'b0;
   logic [11:0]     csr_addr = '0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic [XLEN-1:0] rdata, rdata_off;
   logic            stip, stip_off;
   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   stcu_top #(.XLEN(XLEN), .HAS_TC(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .time_i(time_i), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(rdata), .stip_o(stip));
   stcu_top #(.XLEN(XLEN), .HAS_TC(1'b0)) u_dut_off (
      .clk(clk), .rst_n(rst_n), .time_i(time_i), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(rdata_off), .stip_o(stip_off));

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d, output logic [31:0] d_off);
      csr_addr = a;
      #0.5;
      d = rdata; d_off = rdata_off;
   endtask

   task automatic set_cmp(logic [63:0] v);
      wr(12'h14D, v[31:0]);
      wr(12'h15D, v[63:32]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] r, ro;
      logic [63:0] cv [4];
      cv[0] = 64'h0; cv[1] = 64'h0000_0000_FFFF_FFFF;
      cv[2] = 64'h0000_0001_0000_0000; cv[3] = 64'h8000_0000_0000_0002;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 / R1 reset state
      chk("R9 stip after reset", stip, 0);
      rd(12'h14D, r, ro); chk("R1 low half reset", r, 32'hFFFF_FFFF);
      rd(12'h15D, r, ro); chk("R1 high half reset", r, 32'hFFFF_FFFF);
      rd(12'h31A, r, ro); chk("R9 enable reset", r, 0);
      rd(12'h344, r, ro); chk("R9 latch reset", r, 0);

      // R8 enable location, R10 absent variant
      wr(12'h31A, 32'hFFFF_FFFF);
      rd(12'h31A, r, ro);
      chk("R8 enable bit 31 only", r, 32'h8000_0000);
      chk("R10 enable absent reads 0", ro, 0);
      rd(12'h30A, r, ro); chk("R8 low env half not owned", r, 0);

      // R2 halves
      wr(12'h14D, 32'h1234_5678);
      rd(12'h14D, r, ro); chk("R2 low written", r, 32'h1234_5678);
      rd(12'h15D, r, ro); chk("R2 high kept", r, 32'hFFFF_FFFF);
      wr(12'h15D, 32'h0000_00A5);
      rd(12'h14D, r, ro); chk("R2 low kept", r, 32'h1234_5678);
      rd(12'h15D, r, ro); chk("R2 high written", r, 32'h0000_00A5);

      // R3 sweep around compare values (unsigned, wrapping offsets)
      foreach (cv[i]) begin
         set_cmp(cv[i]);
         for (int d = -3; d <= 3; d++) begin
            logic [63:0] t;
            t = cv[i] + 64'(signed'(d));
            time_i = t;
            @(negedge clk);
            chk($sformatf("R3 cmp=%h t=%h", cv[i], t), stip, (t >= cv[i]) ? 1 : 0);
         end
      end

      // R4 / R5 holding and clearing
      set_cmp(64'd100);
      time_i = 64'd200;
      @(negedge clk);
      chk("R4 pending set", stip, 1);
      time_i = 64'd300;
      @(negedge clk);
      chk("R4 still pending", stip, 1);
      time_i = 64'd50;
      #0.5 chk("R5 no change before edge", stip, 1);
      @(negedge clk);
      chk("R5 change after one edge", stip, 0);
      time_i = 64'd300;
      @(negedge clk);
      chk("R4 pending again", stip, 1);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = 12'h14D; csr_wdata = 32'd1000;
      @(negedge clk);
      csr_we = 1'b0;
      chk("R5 write not yet visible", stip, 1);
      @(negedge clk);
      chk("R4 cleared by larger compare", stip, 0);

      // R7 latch ignored while enabled
      set_cmp(64'hFFFF_FFFF_FFFF_FFF0);
      time_i = 64'd5;
      wr(12'h344, 32'h0000_0020);
      chk("R7 stip follows compare", stip, 0);
      chk("R10 absent follows latch", stip_off, 1);
      rd(12'h344, r, ro);
      chk("R7 mip read enabled", r, 0);
      chk("R10 mip read absent", ro, 32'h20);

      // R6 latch drives output when disabled
      wr(12'h31A, 32'h0);
      chk("R7 write was ignored", stip, 0);
      set_cmp(64'd0);
      @(negedge clk);
      chk("R6 comparator masked", stip, 0);
      wr(12'h344, 32'hFFFF_FFDF);
      chk("R6 only bit5 counts", stip, 0);
      wr(12'h344, 32'h0000_0020);
      chk("R6 latch set", stip, 1);
      rd(12'h344, r, ro); chk("R6 mip readback", r, 32'h20);
      set_cmp(64'hFFFF_FFFF_FFFF_FFFF);
      time_i = 64'd0;
      @(negedge clk);
      chk("R6 latch holds vs comparator", stip, 1);
      wr(12'h344, 32'h0);
      chk("R6 latch clear", stip, 0);

      // R10 enable write ignored in absent variant
      wr(12'h31A, 32'h8000_0000);
      wr(12'h344, 32'h20);
      chk("R10 absent still follows latch", stip_off, 1);
      chk("R8 enabled dut ignores latch", stip, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule